// File: doc/BRIEF.md
# Dual-Channel Pulse Modulator with Density Mode

This peripheral drives two independent output pins from a shared pulse-rate strobe. Software programs it through a flat 32-bit register port with a single-cycle write strobe and a combinational read path. Each channel owns a range register (the period length in strobes) and a data register (how many of those strobes are active). A shared control word turns each channel on, selects its algorithm, inverts its polarity and sets the level it rests at when stopped.

Two algorithms are offered per channel. Mark-space mode groups the active strobes at the start of every period, which gives a plain duty cycle. Density mode spreads the same number of active strobes evenly across the range by means of a running accumulator, which pushes the energy to higher frequencies and makes a cheap RC filter more effective. The outputs advance only on strobes of `tick_i`, so the pulse rate is set by whatever divider feeds that pin.

Top module: `pwm_dual`

## Requirements
- R1: While reset is asserted and directly after it, every register reads 0 and both outputs are 0.
- R2: The control word at offset 0x00 holds one byte per channel (channel 0 in bits 7:0, channel 1 in bits 15:8). Within a byte, bit 0 is run, bit 1 is serial-select, bit 2 is repeat, bit 3 is the rest level, bit 4 is invert, bit 5 is queue-select and bit 7 is mark-space select. Bit 6 of each byte is not stored and reads 0 (so bits 6 and 14 read 0), and bits 31:16 read 0.
- R3: Range and data registers sit at 0x10 and 0x14 for channel 0 and at 0x20 and 0x24 for channel 1. They read back the value last written.
- R4: Offsets 0x04, 0x08 and 0x18 always read 0, and writes to them change no register and no output.
- R5: A channel whose run bit is 0 drives its rest-level bit on its output, starting one clock after the control write takes effect.
- R6: In mark-space mode, each period of RANGE strobes begins with DATA active strobes followed by RANGE minus DATA inactive strobes.
- R7: In mark-space mode, a new range or data value written while the channel runs takes effect only at the start of the next period.
- R8: In density mode, each strobe adds DATA to an accumulator. If the sum is at least RANGE, RANGE is subtracted and the strobe is active; otherwise the sum is kept and the strobe is inactive. A change of range or data takes effect at the next strobe and clears the accumulator.
- R9: In both modes, DATA greater than or equal to RANGE makes every strobe active, and DATA of 0 with a nonzero RANGE makes every strobe inactive.
- R10: The invert bit flips the pulse level of a running channel.
- R11: A 0-to-1 change of the run bit restarts the period counter and the accumulator from zero.
- R12: The serial-select, repeat and queue-select bits are stored but do not change the output waveform.
- R13: A running channel changes its output only on clocks where `tick_i` is high. Each strobe's level appears on the output one clock after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register access |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| tick_i | input | 1 | Pulse-rate strobe that advances both channels |
| pwm_o | output | 2 | Channel outputs, bit 0 for channel 0 |

## Verification
The bench goes after the period boundary in mark-space mode by rewriting range and data in the middle of a period. A design that reloads at once would cut the old period short and show the new duty too early. It also drives saturated and empty ratios in both modes, where a missing clamp either lets the accumulator run away or loses the all-on level. It restarts one channel in the middle of a period while the other keeps running, which exposes a design that fails to clear the counter or the accumulator on enable, or that couples the two channels. Finally it writes the dead offsets and the inert control bits and checks that the readback and the waveform stay exactly as the model predicts.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int NCH      = 2;
  localparam int CH_BITS  = 8;
  localparam int OFS_CTL  = 'h00;
  localparam int OFS_STA  = 'h04;
  localparam int OFS_DMA  = 'h08;
  localparam int OFS_QUE  = 'h18;
  localparam int OFS_RNG0 = 'h10;
  localparam int OFS_DAT0 = 'h14;
  localparam int CH_STEP  = 'h10;

  typedef struct packed {
    logic ms;
    logic que;
    logic pol;
    logic sil;
    logic rpt;
    logic ser;
    logic en;
  } ch_cfg_t;

  function automatic ch_cfg_t cfg_unpack(input logic [CH_BITS-1:0] b);
    ch_cfg_t c;
    c.en  = b[0];
    c.ser = b[1];
    c.rpt = b[2];
    c.sil = b[3];
    c.pol = b[4];
    c.que = b[5];
    c.ms  = b[7];
    return c;
  endfunction

  function automatic logic [CH_BITS-1:0] cfg_pack(input ch_cfg_t c);
    return {c.ms, 1'b0, c.que, c.pol, c.sil, c.rpt, c.ser, c.en};
  endfunction
endpackage

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
  import pwm_dual_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RNG_W  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic [NCH-1:0]                en_o,
  output logic [NCH-1:0]                ms_o,
  output logic [NCH-1:0]                pol_o,
  output logic [NCH-1:0]                sil_o,
  output logic [NCH-1:0][RNG_W-1:0]     rng_o,
  output logic [NCH-1:0][RNG_W-1:0]     dat_o
);
  ch_cfg_t [NCH-1:0]             cfg_q;
  logic    [NCH-1:0][RNG_W-1:0]  rng_q, dat_q;
  logic    [NCH-1:0]             rng_hit, dat_hit;
  logic                          ctl_hit, dead_hit;

  assign ctl_hit  = addr_i == ADDR_W'(OFS_CTL);
  assign dead_hit = (addr_i == ADDR_W'(OFS_STA)) || (addr_i == ADDR_W'(OFS_DMA)) ||
                    (addr_i == ADDR_W'(OFS_QUE));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign rng_hit[ch] = addr_i == ADDR_W'(OFS_RNG0 + ch * CH_STEP);
    assign dat_hit[ch] = addr_i == ADDR_W'(OFS_DAT0 + ch * CH_STEP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[ch] <= '0;
        rng_q[ch] <= '0;
        dat_q[ch] <= '0;
      end else if (we_i) begin
        if (ctl_hit)     cfg_q[ch] <= cfg_unpack(wdata_i[ch*CH_BITS +: CH_BITS]);
        if (rng_hit[ch]) rng_q[ch] <= wdata_i[RNG_W-1:0];
        if (dat_hit[ch]) dat_q[ch] <= wdata_i[RNG_W-1:0];
      end
    end

    assign en_o[ch]  = cfg_q[ch].en;
    assign ms_o[ch]  = cfg_q[ch].ms;
    assign pol_o[ch] = cfg_q[ch].pol;
    assign sil_o[ch] = cfg_q[ch].sil;
    assign rng_o[ch] = rng_q[ch];
    assign dat_o[ch] = dat_q[ch];
  end

  always_comb begin
    rdata_o = '0;
    if (ctl_hit) begin
      for (int ch = 0; ch < NCH; ch++) rdata_o[ch*CH_BITS +: CH_BITS] = cfg_pack(cfg_q[ch]);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (rng_hit[ch]) rdata_o = 32'(rng_q[ch]);
      if (dat_hit[ch]) rdata_o = 32'(dat_q[ch]);
    end
  end

  // R2: clear positions never read back as 1
  a_r2_spare_bits_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_hit |-> (!rdata_o[6] && !rdata_o[14]));

  a_r4_dead_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_hit |-> rdata_o == '0);

  a_r4_dead_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dead_hit) |=> ($stable(cfg_q) && $stable(rng_q) && $stable(dat_q)));
endmodule

// File: rtl/pwm_dual_chan.sv
module pwm_dual_chan #(
  parameter int RNG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             ms_i,
  input  logic             pol_i,
  input  logic             sil_i,
  input  logic [RNG_W-1:0] rng_i,
  input  logic [RNG_W-1:0] dat_i,
  output logic             out_o
);
  logic [RNG_W-1:0] cnt_q, acc_q, rng_l, dat_l;
  logic [RNG_W:0]   sum;
  logic             out_q, full, ms_bit, dt_bit, wrap, cfg_chg;

  assign full    = dat_l >= rng_l;
  assign ms_bit  = full || (cnt_q < dat_l);
  assign wrap    = ({1'b0, cnt_q} + 1'b1) >= {1'b0, rng_l};
  assign sum     = {1'b0, acc_q} + {1'b0, dat_l};
  assign dt_bit  = full || (sum >= {1'b0, rng_l});
  assign cfg_chg = (rng_i != rng_l) || (dat_i != dat_l);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      rng_l <= '0;
      dat_l <= '0;
      out_q <= 1'b0;
    end else if (!en_i) begin
      // stopped: hold restart state and track live settings
      cnt_q <= '0;
      acc_q <= '0;
      rng_l <= rng_i;
      dat_l <= dat_i;
      out_q <= sil_i;
    end else if (tick_i) begin
      if (ms_i) begin
        out_q <= ms_bit ^ pol_i;
        acc_q <= '0;
        if (wrap) begin
          cnt_q <= '0;
          rng_l <= rng_i;
          dat_l <= dat_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        out_q <= dt_bit ^ pol_i;
        cnt_q <= '0;
        if (cfg_chg) begin
          rng_l <= rng_i;
          dat_l <= dat_i;
          acc_q <= '0;
        end else if (!full) begin
          acc_q <= dt_bit ? RNG_W'(sum - {1'b0, rng_l}) : sum[RNG_W-1:0];
        end
      end
    end
  end

  assign out_o = out_q;

  a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> out_o == $past(sil_i));

  a_r13_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(out_o));

  a_r6_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ms_i && rng_l != '0) |-> cnt_q < rng_l);

  a_r8_acc_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == '0) || (acc_q < rng_l));

  a_r11_restart_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (cnt_q == '0 && acc_q == '0));
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
  import pwm_dual_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RNG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  output logic [NCH-1:0]    pwm_o
);
  logic [NCH-1:0]             en, ms, pol, sil;
  logic [NCH-1:0][RNG_W-1:0]  rng, dat;

  pwm_dual_regs #(.ADDR_W(ADDR_W), .RNG_W(RNG_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .ms_o    (ms),
    .pol_o   (pol),
    .sil_o   (sil),
    .rng_o   (rng),
    .dat_o   (dat)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_dual_chan #(.RNG_W(RNG_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .en_i   (en[ch]),
      .ms_i   (ms[ch]),
      .pol_i  (pol[ch]),
      .sil_i  (sil[ch]),
      .rng_i  (rng[ch]),
      .dat_i  (dat[ch]),
      .out_o  (pwm_o[ch])
    );
  end
endmodule

// File: tb/sim_pwm_dual.sv
`timescale 1ns/1ps
module sim_pwm_dual;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_i = 1'b0;
  logic [1:0]  pwm_o;

  pwm_dual u0 (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // independent model state
  logic [31:0]     r_ctl = '0;
  longint unsigned r_rng[2], r_dat[2], m_rng[2], m_dat[2], m_cnt[2], m_acc[2];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    #2;
    chk(rdata_o == e, req, rdata_o, e);
  endtask

  task automatic set_reg(input int c, input bit is_dat, input longint unsigned v);
    if (is_dat) begin r_dat[c] = v; wr(8'(8'h14 + c*16), 32'(v)); end
    else        begin r_rng[c] = v; wr(8'(8'h10 + c*16), 32'(v)); end
  endtask

  task automatic set_ctl(input logic [31:0] v);
    for (int c = 0; c < 2; c++) begin
      if (v[8*c] && !r_ctl[8*c]) begin
        m_cnt[c] = 0; m_acc[c] = 0; m_rng[c] = r_rng[c]; m_dat[c] = r_dat[c];
      end
    end
    r_ctl = v;
    wr(8'h00, v);
  endtask

  function automatic logic step(input int c);
    logic b, full;
    longint unsigned sum;
    full = m_dat[c] >= m_rng[c];
    if (r_ctl[8*c+7]) begin
      b = full || (m_cnt[c] < m_dat[c]);
      m_acc[c] = 0;
      if (m_cnt[c] + 1 >= m_rng[c]) begin
        m_cnt[c] = 0; m_rng[c] = r_rng[c]; m_dat[c] = r_dat[c];
      end else m_cnt[c]++;
    end else begin
      sum = m_acc[c] + m_dat[c];
      b = full || (sum >= m_rng[c]);
      m_cnt[c] = 0;
      if (r_rng[c] != m_rng[c] || r_dat[c] != m_dat[c]) begin
        m_rng[c] = r_rng[c]; m_dat[c] = r_dat[c]; m_acc[c] = 0;
      end else if (!full) m_acc[c] = b ? sum - m_rng[c] : sum;
    end
    return b;
  endfunction

  task automatic ticks(input int n, input int gap);
    logic [1:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      for (int c = 0; c < 2; c++)
        e[c] = r_ctl[8*c] ? (step(c) ^ r_ctl[8*c+4]) : r_ctl[8*c+3];
      exp_q.push_back(e); tag_q.push_back(cur_req);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      if (gap > 0) begin
        repeat (gap) @(negedge clk_i);
        chk(pwm_o == e, "R13", pwm_o, e);   // held between strobes
      end
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk_i);
      if (tick_i) begin
        logic [1:0] e;
        string t;
        @(negedge clk_i);
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(pwm_o == e, t, pwm_o, e);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      r_rng[c] = 0; r_dat[c] = 0; m_rng[c] = 0; m_dat[c] = 0; m_cnt[c] = 0; m_acc[c] = 0;
    end
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(pwm_o == 2'b00, "R1", pwm_o, 0);
    rd_chk(8'h00, 0, "R1");
    rst_ni = 1'b1;
    rd_chk(8'h10, 0, "R1");
    rd_chk(8'h24, 0, "R1");
    chk(pwm_o == 2'b00, "R1", pwm_o, 0);

    // R2 control readback
    cur_req = "R2";
    set_ctl(32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h0000_BFBF, "R2");
    set_ctl(32'h0);
    rd_chk(8'h00, 32'h0, "R2");

    // R3 range/data readback
    set_reg(0, 0, 10); set_reg(0, 1, 3); set_reg(1, 0, 7); set_reg(1, 1, 5);
    rd_chk(8'h10, 10, "R3"); rd_chk(8'h14, 3, "R3");
    rd_chk(8'h20, 7, "R3");  rd_chk(8'h24, 5, "R3");

    // R4 dead offsets
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h18, 32'h1234); wr(8'h04, 32'hAB);
    rd_chk(8'h08, 0, "R4"); rd_chk(8'h18, 0, "R4"); rd_chk(8'h04, 0, "R4");
    rd_chk(8'h10, 10, "R4"); rd_chk(8'h00, 0, "R4");
    chk(pwm_o == 2'b00, "R4", pwm_o, 0);

    // R5 rest levels
    set_ctl(32'h0000_0008);
    @(negedge clk_i);
    chk(pwm_o == 2'b01, "R5", pwm_o, 2'b01);
    set_ctl(32'h0000_0800);
    @(negedge clk_i);
    chk(pwm_o == 2'b10, "R5", pwm_o, 2'b10);
    set_ctl(32'h0);

    // R6 mark-space on both channels
    cur_req = "R6";
    set_reg(0, 0, 4); set_reg(0, 1, 1); set_reg(1, 0, 5); set_reg(1, 1, 2);
    set_ctl(32'h0000_8181);
    ticks(12, 0);
    ticks(3, 2);

    // R7 deferred update mid-period
    cur_req = "R7";
    ticks(2, 0);
    set_reg(0, 1, 3); set_reg(0, 0, 6);
    ticks(12, 1);

    // R11 restart channel 0 while channel 1 runs
    cur_req = "R11";
    ticks(2, 0);
    set_ctl(32'h0000_8180);
    set_ctl(32'h0000_8181);
    ticks(8, 0);

    // R8 density mode
    cur_req = "R8";
    set_ctl(32'h0);
    set_reg(0, 0, 5); set_reg(0, 1, 2); set_reg(1, 0, 7); set_reg(1, 1, 3);
    set_ctl(32'h0000_0101);
    ticks(20, 0);

    // R9 saturated and empty ratios
    cur_req = "R9";
    set_ctl(32'h0);
    set_reg(0, 0, 4); set_reg(0, 1, 4); set_reg(1, 0, 6); set_reg(1, 1, 0);
    set_ctl(32'h0000_0101);
    ticks(8, 0);
    set_ctl(32'h0);
    set_reg(0, 0, 3); set_reg(0, 1, 9);
    set_ctl(32'h0000_8181);
    ticks(8, 0);

    // R10 invert
    cur_req = "R10";
    set_ctl(32'h0);
    set_reg(0, 0, 4); set_reg(0, 1, 1); set_reg(1, 0, 5); set_reg(1, 1, 2);
    set_ctl(32'h0000_1191);
    ticks(10, 0);

    // R12 inert bits
    cur_req = "R12";
    set_ctl(32'h0);
    set_ctl(32'h0000_A7E7);
    rd_chk(8'h00, 32'h0000_A7A7, "R12");
    ticks(10, 0);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R13", exp_q.size(), 0);
    finish_up();
  end
endmodule